// File: doc/BRIEF.md
# Pin Level-Change Interrupt Unit

This block watches a vector of already synchronized (and, where wanted, already filtered) pin levels. It flags every level change on every implemented line into a sticky event register. It then combines those events with a per-line enable mask and raises one level-type interrupt request toward the system interrupt controller. The block has no notion of who owns a pin or which way it points. Every sampled line is watched all the time, so an event is recorded whether the line is driven by a peripheral, by software or from outside.

Software reaches the block through a small register bus with four word locations:

| Location | Access | Effect |
|---|---|---|
| 0 | write | Sets mask bits |
| 1 | write | Clears mask bits |
| 2 | read | Mask readback |
| 3 | read | Event register; the read consumes it |

A read request is answered one cycle later with a data-valid strobe. Every read is accepted, so the bus has no back-pressure. Only the low `NUM_LINES` bits of the 32-bit data word are implemented.

Top module: `pin_event_irq`

## Requirements
- R1: A change of level in either direction on an implemented line, compared with its value in the previous cycle, sets that line's event bit at the next clock edge. The bit stays set until the event register is read.
- R2: A write to location 0 sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R3: A write to location 1 clears every mask bit whose data bit is 1 and leaves the others unchanged. A read of location 2 returns the mask.
- R4: `irq_o` is registered. It is 1 in the cycle after any event bit and its mask bit are both 1, and 0 in the cycle after no such pair exists. Clearing the mask bit drops it even while the event stays set.
- R5: A read of location 3 returns the event register and clears it in the same clock edge.
- R6: A change that arrives in the same cycle as a read of location 3 is not lost. The read returns the old value, and the new bit is set afterwards.
- R7: Data bits at positions `NUM_LINES` and above read as 0, and writes to them have no effect.
- R8: Lines that sit at a non-zero level during reset flag no change in the first cycle after reset.
- R9: After reset the mask, the event register, `irq_o` and `rd_valid_o` are all 0.
- R10: `rd_valid_o` and `rd_data_o` follow a read request by exactly one cycle. Reads of the write-only locations 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_i | input | NUM_LINES | Synchronized pin levels |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read request, always accepted |
| addr_i | input | 2 | Word location |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid with `rd_valid_o` |
| rd_valid_o | output | 1 | Read response strobe |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench drives single-line rises and falls to show that both directions are caught. It drives several lines changing at once to confirm the bits are captured independently. A change on a masked-off line shows that an event is stored without raising the request. A change placed in the same cycle as an event read separates a correct merge of set and clear from one that drops the new event. Holding non-zero levels through reset and writing 1s into the unimplemented upper bits tell apart a correct start-up and bit-width limit from a design that flags phantom events or keeps bits that do not exist.

// File: rtl/pei_pkg.sv
package pei_pkg;
  localparam int BUS_W = 32;
  typedef enum logic [1:0] {
    LOC_MASK_SET  = 2'd0,
    LOC_MASK_CLR  = 2'd1,
    LOC_MASK_VIEW = 2'd2,
    LOC_EVENTS    = 2'd3
  } loc_e;
endpackage

// File: rtl/pei_change_detect.sv
module pei_change_detect #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] change_o
);
  logic [N-1:0] prev_q;

  // During reset the history follows the pins, so the first cycle is quiet.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= pins_i;
    else     prev_q <= pins_i;
  end

  assign change_o = pins_i ^ prev_q;

  // R8: first cycle after reset, stable pins give no change
  a_r8_quiet_start: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $stable(pins_i)) |-> (change_o == '0));
endmodule

// File: rtl/pei_event_status.sv
module pei_event_status #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] change_i,
  input  logic         clear_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;
  logic [N-1:0] status_d;

  // New events win over the clear, so a collision loses nothing.
  always_comb begin
    status_d = clear_i ? '0 : status_q;
    status_d = status_d | change_i;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  assign status_o = status_q;

  // R1: every changed line is flagged at the next edge
  a_r1_change_sets: assert property (@(posedge clk) disable iff (rst)
    (change_i != '0) |=> ((status_q & $past(change_i)) == $past(change_i)));
  // R5/R6: after a clear only coincident changes remain
  a_r6_clear_keeps_new: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (status_q == $past(change_i)));
  // R1: without clear, bits never drop
  a_r1_sticky: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/pei_mask_reg.sv
module pei_mask_reg #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)           mask_q <= '0;
    else if (set_we_i) mask_q <= mask_q | bits_i;
    else if (clr_we_i) mask_q <= mask_q & ~bits_i;
  end

  assign mask_o = mask_q;

  // R2: set write turns on the selected bits and keeps the rest
  a_r2_mask_set: assert property (@(posedge clk) disable iff (rst)
    set_we_i |=> (mask_q == ($past(mask_q) | $past(bits_i))));
  // R3: clear write turns off the selected bits and keeps the rest
  a_r3_mask_clr: assert property (@(posedge clk) disable iff (rst)
    (clr_we_i && !set_we_i) |=> ((mask_q & $past(bits_i)) == '0));
  a_r3_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_we_i && !set_we_i) |=> $stable(mask_q));
endmodule

// File: rtl/pei_bus_port.sv
module pei_bus_port
  import pei_pkg::*;
#(
  parameter int N = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     status_i,
  output logic             set_we_o,
  output logic             clr_we_o,
  output logic [N-1:0]     bits_o,
  output logic             status_clr_o,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  loc_e             loc;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rd_data_q;
  logic             rd_valid_q;

  assign loc          = loc_e'(addr_i);
  assign set_we_o     = wr_en_i && (loc == LOC_MASK_SET);
  assign clr_we_o     = wr_en_i && (loc == LOC_MASK_CLR);
  assign bits_o       = wr_data_i[N-1:0];
  assign status_clr_o = rd_en_i && (loc == LOC_EVENTS);

  // Upper bits stay zero: only N lines exist.
  always_comb begin
    rd_mux = '0;
    unique case (loc)
      LOC_MASK_VIEW: rd_mux[N-1:0] = mask_i;
      LOC_EVENTS:    rd_mux[N-1:0] = status_i;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_data_q <= rd_mux;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;

  // R10: response exactly one cycle after the request
  a_r10_resp_timing: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_valid_o);
  // R5: event read returns the pre-clear value
  a_r5_read_old: assert property (@(posedge clk) disable iff (rst)
    status_clr_o |=> (rd_data_o[N-1:0] == $past(status_i)));

  generate
    if (N < BUS_W) begin : g_upper
      // R7: unimplemented bits read as zero
      a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> (rd_data_o[BUS_W-1:N] == '0));
    end
  endgenerate
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pei_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [1:0]           addr_i,
  input  logic [31:0]          wr_data_i,
  output logic [31:0]          rd_data_o,
  output logic                 rd_valid_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] change;
  logic [NUM_LINES-1:0] status;
  logic [NUM_LINES-1:0] mask;
  logic [NUM_LINES-1:0] bits;
  logic                 set_we;
  logic                 clr_we;
  logic                 status_clr;
  logic                 irq_q;

  pei_change_detect #(.N(NUM_LINES)) u_detect (
    .clk(clk), .rst(rst), .pins_i(pins_i), .change_o(change)
  );

  pei_event_status #(.N(NUM_LINES)) u_status (
    .clk(clk), .rst(rst), .change_i(change), .clear_i(status_clr),
    .status_o(status)
  );

  pei_mask_reg #(.N(NUM_LINES)) u_mask (
    .clk(clk), .rst(rst), .set_we_i(set_we), .clr_we_i(clr_we),
    .bits_i(bits), .mask_o(mask)
  );

  pei_bus_port #(.N(NUM_LINES)) u_bus (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .mask_i(mask),
    .status_i(status), .set_we_o(set_we), .clr_we_o(clr_we),
    .bits_o(bits), .status_clr_o(status_clr), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status & mask);
  end

  assign irq_o = irq_q;

  // R4: request rises one cycle after an enabled event exists
  a_r4_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|(status & mask)) |=> irq_o);
  // R4: request falls one cycle after no enabled event remains
  a_r4_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(|(status & mask)) |=> !irq_o);
endmodule

// File: tb/pin_event_irq_bench.sv
module pin_event_irq_bench;
  localparam int NL = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] pins = 24'h00A5A5;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  pin_event_irq #(.NUM_LINES(NL)) u_pin_event_irq (
    .clk(clk), .rst(rst), .pins_i(pins), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .rd_valid_o(rvalid), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  // Driver: push the expected response, then issue the request.
  task automatic rd(input logic [1:0] a, input logic [31:0] exp,
                    input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  // Monitor: pop and compare each response.
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (sb.size() == 0) begin
        check(rdata, 32'hDEAD_BEEF, "R10 unexpected response");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rdata, e.val, e.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    check({31'd0, irq}, 32'd0, "R9 irq after reset");
    check({31'd0, rvalid}, 32'd0, "R9 rd_valid after reset");
    rd(2'd3, 32'h0, "R8 no event from reset-time levels");
    rd(2'd2, 32'h0, "R9 mask after reset");

    wr(2'd0, 32'hFF00_0F0F);
    rd(2'd2, 32'h0000_0F0F, "R2 R7 mask set, upper bits dropped");
    wr(2'd1, 32'hFFFF_0F00);
    rd(2'd2, 32'h0000_000F, "R3 mask clear");
    wr(2'd0, 32'h0000_0010);
    rd(2'd2, 32'h0000_001F, "R2 set keeps others");

    pins = 24'h00A5A4;              // falling edge on line 0
    tick(); tick();
    check({31'd0, irq}, 32'd1, "R4 irq rises for enabled event");
    rd(2'd3, 32'h0000_0001, "R1 R5 falling edge flagged");
    tick();
    check({31'd0, irq}, 32'd0, "R4 irq falls after read clear");
    rd(2'd3, 32'h0, "R5 read cleared events");

    pins = 24'h10A5A4;              // rising edge on masked-off line 20
    tick(); tick();
    check({31'd0, irq}, 32'd0, "R4 masked event raises no irq");
    rd(2'd3, 32'h0010_0000, "R1 rising edge stored while masked");

    pins = 24'h10A5B4;              // line 4
    tick(); tick();
    pins = 24'h10A5B6;              // line 1, same cycle as the read
    rd(2'd3, 32'h0000_0010, "R6 read returns old events");
    rd(2'd3, 32'h0000_0002, "R6 coincident event kept");

    pins = 24'h10A5B7;              // line 0 again
    tick(); tick();
    check({31'd0, irq}, 32'd1, "R4 irq set again");
    wr(2'd1, 32'h0000_001F);
    tick();
    check({31'd0, irq}, 32'd0, "R4 mask disable drops irq");
    rd(2'd0, 32'h0, "R10 write-only location reads zero");
    rd(2'd1, 32'h0, "R10 write-only location reads zero");
    rd(2'd3, 32'h0000_0001, "R4 event stays after mask disable");

    pins = 24'h1FA5B7;              // four lines at once
    tick(); tick();
    rd(2'd3, 32'h000F_0000, "R1 several lines at once");
    rd(2'd3, 32'h0, "R1 stable pins flag nothing");

    repeat (3) tick();
    done = 1;
    if (sb.size() != 0)
      check(sb.size(), 0, "R10 missing responses");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule